// File: doc/BRIEF.md
# IPI Send Command Dispatcher

This block turns a single inter-processor interrupt send command into a set request for one core's interrupt status register. A command arrives as a 32-bit word with a one-cycle valid strobe. The block extracts two fields from the word: a target core number and an interrupt vector number. It turns the vector into a one-hot 32-bit mask and presents that mask on the set port of the addressed core.

The set port behaves like a direct software write to that core's set register. The per-core block that receives it ORs the mask into its status and performs its own raise check; that aggregation is outside this block. Core numbers map one-to-one onto port indices. A command whose core number is not below the configured core count produces a decode-error pulse and changes no core.

The dispatcher accepts a command on every cycle and never stalls the sender. Every result appears on the cycle after the command.

Top module: `ipi_send_dispatch`

## Requirements
- R1: The target core number is taken from command bits 25:16 (10 bits, unsigned). Core number N drives port index N.
- R2: The vector is taken from command bits 4:0. The mask presented to the target core has exactly bit `vector` set (mask = 1 << vector) and every other bit clear.
- R3: For a command accepted on clock edge k, the results are registered and visible after edge k. They last exactly one cycle unless another command follows.
- R4: A command whose core number is greater than or equal to NUM_CORES raises `dec_err` for one cycle, with the same timing as R3. No `set_valid` bit is raised for it.
- R5: At most one bit of `set_valid` is high in any cycle, and `dec_err` is never high in the same cycle as any `set_valid` bit.
- R6: Command bits 31:26 and 15:5 have no effect on any output.
- R7: A new command may be presented on every cycle with no back-pressure. Each command in a back-to-back stream produces its own result in consecutive cycles.
- R8: In a cycle that follows an edge without `cmd_valid`, `set_valid` and `dec_err` are low and all of `set_mask` is zero. A core's mask slice is zero whenever its `set_valid` bit is low.
- R9: While `rst` is high (synchronous, active-high), the outputs are cleared: `set_valid`, `set_mask` and `dec_err` are zero, even if `cmd_valid` is high.
- R10: NUM_CORES must lie between 1 and 1024. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Send command strobe, one command per high cycle |
| cmd_data | input | 32 | Send command word (core number at 25:16, vector at 4:0) |
| dec_err | output | 1 | One-cycle pulse when the core number is out of range |
| set_valid | output | NUM_CORES | One-cycle set request, one bit per core |
| set_mask | output | NUM_CORES*32 | Per-core set mask; core i occupies bits 32*i+31 down to 32*i |

## Verification
The bench builds the dispatcher with NUM_CORES = 5. Five is not a power of two, so core numbers 5 to 7 fit in the low index bits and yet must be rejected. This exercises the full-width range compare at the boundary between 4 and 5, as well as the far edge at 1023. With five ports, a mis-steered mask shows up as a wrong slice of `set_mask`, and the bench compares the whole bus on every cycle. Random words carry noise in the unused bits, so any leak from those bits into the outputs is caught.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;

    // Command field layout (fixed by the command format)
    localparam int TGT_LSB  = 16;
    localparam int TGT_W    = 10;
    localparam int VEC_LSB  = 0;
    localparam int VEC_W    = 5;
    localparam int MASK_W   = 1 << VEC_W;
    localparam int CMD_W    = 32;
    localparam int MAX_CORES = 1 << TGT_W;

    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [TGT_W-1:0]  tgt_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [MASK_W-1:0] mask_t;

    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_SET    = 2'd1,
        RSP_DECERR = 2'd2
    } rsp_kind_t;

    typedef struct packed {
        rsp_kind_t kind;
        tgt_t      tgt;
        vec_t      vec;
    } dec_cmd_t;

    function automatic tgt_t get_tgt(input cmd_t c);
        return c[TGT_LSB +: TGT_W];
    endfunction

    function automatic vec_t get_vec(input cmd_t c);
        return c[VEC_LSB +: VEC_W];
    endfunction

    function automatic mask_t vec_to_mask(input vec_t v);
        mask_t m;
        for (int b = 0; b < MASK_W; b++) begin
            m[b] = (vec_t'(b) == v);
        end
        return m;
    endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic     cmd_valid,
    input  cmd_t     cmd_data,
    output dec_cmd_t dec
);
    tgt_t tgt;
    logic in_range;

    always_comb begin
        tgt      = get_tgt(cmd_data);
        in_range = (32'(tgt) < 32'(NUM_CORES));
        dec.tgt  = tgt;
        dec.vec  = get_vec(cmd_data);
        if (!cmd_valid) begin
            dec.kind = RSP_IDLE;
        end else if (in_range) begin
            dec.kind = RSP_SET;
        end else begin
            dec.kind = RSP_DECERR;
        end
    end

endmodule

// File: rtl/ipi_vec_onehot.sv
module ipi_vec_onehot
    import ipi_disp_pkg::*;
(
    input  vec_t  vec,
    output mask_t mask
);
    always_comb begin
        mask = vec_to_mask(vec);
    end
endmodule

// File: rtl/ipi_core_port.sv
module ipi_core_port
    import ipi_disp_pkg::*;
#(
    parameter int CORE_IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  rsp_kind_t kind,
    input  tgt_t      tgt,
    input  mask_t     mask,
    output logic      set_valid,
    output mask_t     set_mask
);
    localparam tgt_t MY_ID = tgt_t'(CORE_IDX);

    logic hit;

    always_comb begin
        hit = (kind == RSP_SET) && (tgt == MY_ID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_valid <= 1'b0;
            set_mask  <= '0;
        end else begin
            set_valid <= hit;
            set_mask  <= hit ? mask : '0;
        end
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic [31:0]                 cmd_data,
    output logic                        dec_err,
    output logic [NUM_CORES-1:0]        set_valid,
    output logic [NUM_CORES*32-1:0]     set_mask
);
    localparam int MASK_BITS = NUM_CORES * MASK_W;

    // R10: core count range check at elaboration
    generate
        if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_count
            $error("NUM_CORES must lie between 1 and 1024");
        end
    endgenerate

    dec_cmd_t dec;
    mask_t    onehot;

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .dec       (dec)
    );

    ipi_vec_onehot u_oh (
        .vec  (dec.vec),
        .mask (onehot)
    );

    logic [MASK_BITS-1:0] mask_bus;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        ipi_core_port #(.CORE_IDX(i)) u_port (
            .clk       (clk),
            .rst       (rst),
            .kind      (dec.kind),
            .tgt       (dec.tgt),
            .mask      (onehot),
            .set_valid (set_valid[i]),
            .set_mask  (mask_bus[i*MASK_W +: MASK_W])
        );
    end

    assign set_mask = mask_bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_err <= 1'b0;
        end else begin
            dec_err <= (dec.kind == RSP_DECERR);
        end
    end

endmodule

// File: rtl/ipi_send_dispatch_chk.sv
module ipi_send_dispatch_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cmd_valid,
    input logic [31:0]             cmd_data,
    input logic                    dec_err,
    input logic [NUM_CORES-1:0]    set_valid,
    input logic [NUM_CORES*32-1:0] set_mask
);
    logic       in_rng;
    logic [9:0] tgt;
    logic [4:0] vec;

    always_comb begin
        tgt    = cmd_data[25:16];
        vec    = cmd_data[4:0];
        in_rng = (32'(tgt) < 32'(NUM_CORES));
    end

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_valid));

    assert_err_excl_R5: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (set_valid == '0));

    assert_target_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && in_rng) |=> (set_valid == (NUM_CORES'(1) << $past(tgt))));

    assert_mask_single_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && in_rng) |=> ($countones(set_mask) == 1));

    assert_mask_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && in_rng) |=> set_mask[int'($past(tgt)) * 32 + int'($past(vec))]);

    assert_decerr_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !in_rng) |=> (dec_err && set_valid == '0));

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!dec_err && set_valid == '0 && set_mask == '0));

    assert_no_err_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && in_rng) |=> !dec_err);

endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .dec_err   (dec_err),
    .set_valid (set_valid),
    .set_mask  (set_mask)
);

// File: tb/sim_ipi_send_dispatch.sv
`timescale 1ns/1ps
module sim_ipi_send_dispatch;
    localparam int NC = 5;

    logic               clk = 1'b0;
    logic               rst;
    logic               cmd_valid;
    logic [31:0]        cmd_data;
    logic               dec_err;
    logic [NC-1:0]      set_valid;
    logic [NC*32-1:0]   set_mask;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(NC)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .dec_err   (dec_err),
        .set_valid (set_valid),
        .set_mask  (set_mask)
    );

    function automatic logic [NC-1:0] exp_valid(input logic v, input logic [31:0] d);
        int id = int'(d[25:16]);
        if (!v || id >= NC) return '0;
        return NC'(1) << id;
    endfunction

    function automatic logic [NC*32-1:0] exp_mask(input logic v, input logic [31:0] d);
        logic [NC*32-1:0] m = '0;
        int id = int'(d[25:16]);
        if (v && id < NC) m[id*32 + int'(d[4:0])] = 1'b1;
        return m;
    endfunction

    function automatic logic exp_err(input logic v, input logic [31:0] d);
        return v && (int'(d[25:16]) >= NC);
    endfunction

    task automatic compare(input logic v, input logic [31:0] d, input string req);
        logic [NC-1:0]    ev = exp_valid(v, d);
        logic [NC*32-1:0] em = exp_mask(v, d);
        logic             ee = exp_err(v, d);
        checks++;
        if (set_valid !== ev || set_mask !== em || dec_err !== ee) begin
            fails++;
            $display("FAIL %s cmd=%h v=%0b: actual valid=%b err=%b mask=%h expected valid=%b err=%b mask=%h",
                     req, d, v, set_valid, dec_err, set_mask, ev, ee, em);
        end
    endtask

    // Called at a negedge: drive, let the edge register it, check at the next negedge
    task automatic step(input logic v, input logic [31:0] d, input string req);
        cmd_valid = v;
        cmd_data  = d;
        @(posedge clk);
        @(negedge clk);
        compare(v, d, req);
    endtask

    function automatic logic [31:0] mk(input int id, input int vec, input logic [31:0] noise);
        logic [31:0] w = noise & 32'hFC00_FFE0;
        w[25:16] = 10'(id);
        w[4:0]   = 5'(vec);
        return w;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            fails++;
            $display("FAIL R7 watchdog expired after %0d cycles (expected completion)", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed      = $urandom(32'd2024);
        rst       = 1'b1;
        cmd_valid = 1'b1;
        cmd_data  = mk(1, 3, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs stay clear under reset even with a command present
        checks++;
        if (set_valid !== '0 || set_mask !== '0 || dec_err !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: actual valid=%b err=%b expected valid=0 err=0", set_valid, dec_err);
        end
        rst       = 1'b0;
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(1'b0, 32'h0, "R9 after reset");

        // Directed corners
        step(1'b1, mk(0, 0, 32'h0),                "R1 R2 core0 vec0");
        step(1'b1, mk(NC-1, 31, 32'h0),            "R1 R2 last core vec31");
        step(1'b1, mk(NC, 4, 32'h0),               "R4 first out-of-range id");
        step(1'b1, mk(1023, 9, 32'h0),             "R4 max id");
        step(1'b1, mk(7, 2, 32'h0),                "R4 id fits index bits");
        step(1'b1, mk(2, 7, 32'hFFFF_FFFF),        "R6 noise bits set");
        step(1'b1, mk(3, 17, 32'hA800_5A40),       "R6 mixed noise");
        step(1'b0, mk(1, 1, 32'h0),                "R8 idle");
        // R7: back-to-back to different cores then to same core
        step(1'b1, mk(1, 5, 32'h0),                "R7 burst a");
        step(1'b1, mk(4, 30, 32'h0),               "R7 burst b");
        step(1'b1, mk(4, 30, 32'h0),               "R7 burst c repeat");
        step(1'b1, mk(600, 1, 32'h0),              "R7 R4 burst err");
        step(1'b1, mk(0, 16, 32'h0),               "R7 burst after err");
        step(1'b0, 32'hFFFF_FFFF,                  "R3 R8 pulse ends");

        // Constrained random
        for (int n = 0; n < 600; n++) begin
            int r   = int'($urandom % 16);
            int id;
            logic v = (r != 0);
            if (r < 12) id = int'($urandom % NC);
            else if (r < 15) id = NC + int'($urandom % 3);
            else id = int'($urandom % 1024);
            step(v, mk(id, int'($urandom % 32), $urandom), "R1 R2 R3 R4 R5 R6 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule